// File: doc/BRIEF.md
# Rotating Register Index Remapper

This block turns logical register numbers into physical register numbers for three register classes: general, floating-point and predicate. Each class splits its register numbers into a low static range that maps one-to-one and an upper rotating region. Inside that region, the logical number is offset by a per-class rename base and wraps around within the region. Software-pipelined loops rely on this: a loop-closing branch raises a rotate command, and after one rotation the value that was reachable under logical register X is reachable under X+1.

Each class has three lookup ports: two sources and one destination. All lookups are purely combinational from the current base values. The only state is one rename-base counter per class. A rotate input moves all three bases down by one step. A clear input returns all three bases to zero. Lookups of the hard-wired constant registers also raise a flag, so that the consumer can substitute the constant value instead of reading storage.

Top module: `rot_reg_remap`

## Requirements
- R1: After reset every rename base is zero, so every logical number maps to the equal physical number in all three classes.
- R2: General and floating logical numbers below the static count (32 by default) map to themselves, whatever the base.
- R3: Predicate logical numbers below the predicate static count (16 by default) map to themselves, whatever the base.
- R4: A general or floating logical number L in the rotating region maps to S + ((L − S + B) mod N), where S is the static count, N = count − S (96 by default) and B is that class's base.
- R5: A predicate logical number in the rotating region follows the same rule, with S = 16 and N = 48 by default.
- R6: A cycle with rot_step high and base_clear low moves each base from B to B−1, and from 0 to N−1. After that cycle, logical X+1 maps to the physical register that logical X mapped to before.
- R7: Rotation wraps: after one rotation, the bottom rotating logical register (general 32, predicate 16) maps to where the top logical register (general 127, predicate 63) mapped before.
- R8: A base always lies in 0..N−1. After exactly N rotations from a zero base, that class's mapping is the identity again, while a class with a different N is not.
- R9: base_clear forces all three bases to zero at the next clock edge, and takes priority over rot_step in the same cycle. With neither input high, the bases hold.
- R10: A general lookup port raises its zero flag exactly when its logical number is 0.
- R11: A floating lookup port drives its constant code as 1 when the logical number is 0 (constant 0.0), 2 when it is 1 (constant +1.0), and 0 otherwise.
- R12: Physical numbers and flags follow the logical inputs in the same cycle, without a clock edge. Each of the three ports of a class maps independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rot_step | input | 1 | Rotate all three bases by one step |
| base_clear | input | 1 | Return all bases to zero |
| gr_src0_log | input | 7 | General source 0 logical number |
| gr_src1_log | input | 7 | General source 1 logical number |
| gr_dst_log | input | 7 | General destination logical number |
| gr_src0_phys | output | 7 | General source 0 physical number |
| gr_src1_phys | output | 7 | General source 1 physical number |
| gr_dst_phys | output | 7 | General destination physical number |
| gr_src0_zero | output | 1 | General source 0 names the zero register |
| gr_src1_zero | output | 1 | General source 1 names the zero register |
| gr_dst_zero | output | 1 | General destination names the zero register |
| fr_src0_log | input | 7 | Floating source 0 logical number |
| fr_src1_log | input | 7 | Floating source 1 logical number |
| fr_dst_log | input | 7 | Floating destination logical number |
| fr_src0_phys | output | 7 | Floating source 0 physical number |
| fr_src1_phys | output | 7 | Floating source 1 physical number |
| fr_dst_phys | output | 7 | Floating destination physical number |
| fr_src0_const | output | 2 | Floating source 0 constant code |
| fr_src1_const | output | 2 | Floating source 1 constant code |
| fr_dst_const | output | 2 | Floating destination constant code |
| pr_src0_log | input | 6 | Predicate source 0 logical number |
| pr_src1_log | input | 6 | Predicate source 1 logical number |
| pr_dst_log | input | 6 | Predicate destination logical number |
| pr_src0_phys | output | 6 | Predicate source 0 physical number |
| pr_src1_phys | output | 6 | Predicate source 1 physical number |
| pr_dst_phys | output | 6 | Predicate destination physical number |

## Verification
The bench builds the block with its default parameters: 128 general and floating registers with 32 static, and 64 predicates with 16 static. That gives rotating regions of 96 and 48. Because the two region sizes differ, a 48-step rotation brings the predicate class back to identity while the general class sits halfway round. A 96-step rotation brings both back, so the wrap of each base counter and the independence of the classes are both within reach in a few hundred cycles.

// File: rtl/rrm_pkg.sv
package rrm_pkg;

    typedef enum logic [1:0] {
        CK_NONE = 2'd0,
        CK_ZERO = 2'd1,
        CK_ONE  = 2'd2
    } const_kind_e;

    // Offset into the rotating region, wrapped with one conditional subtract
    // (both the offset and the base are below sz, so their sum is below 2*sz).
    function automatic int unsigned rot_index(input int unsigned lg,
                                              input int unsigned base,
                                              input int unsigned st,
                                              input int unsigned sz);
        int unsigned off;
        if (lg < st) return lg;
        off = lg - st + base;
        if (off >= sz) off = off - sz;
        return st + off;
    endfunction

    function automatic int unsigned base_after_step(input int unsigned b,
                                                    input int unsigned sz);
        return (b == 0) ? sz - 1 : b - 1;
    endfunction

    function automatic const_kind_e fr_const_kind(input int unsigned lg);
        case (lg)
            0:       return CK_ZERO;
            1:       return CK_ONE;
            default: return CK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rrm_base_ctr.sv
module rrm_base_ctr
    import rrm_pkg::*;
#(
    parameter int unsigned SIZE = 96,
    parameter int unsigned W    = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    output logic [W-1:0] base
);

    always_ff @(posedge clk) begin
        if (rst || clr)
            base <= '0;
        else if (step)
            base <= W'(base_after_step(32'(base), SIZE));
    end

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (base == '0));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!clr && !step) |=> $stable(base));

    assert_step_down_R6: assert property (@(posedge clk) disable iff (rst)
        (step && !clr) |=> ((($past(base) == '0) && (32'(base) == SIZE - 1)) ||
                            (32'(base) + 1 == 32'($past(base)))));

    assert_base_range_R8: assert property (@(posedge clk) disable iff (rst)
        32'(base) < SIZE);

endmodule

// File: rtl/rrm_lookup.sv
module rrm_lookup
    import rrm_pkg::*;
#(
    parameter int unsigned COUNT  = 128,
    parameter int unsigned STATIC = 32,
    parameter int unsigned IW     = 7,
    parameter int unsigned BW     = 7
) (
    input  logic [IW-1:0] log_idx,
    input  logic [BW-1:0] base,
    output logic [IW-1:0] phys_idx
);

    localparam int unsigned SIZE = COUNT - STATIC;

    always_comb begin
        phys_idx = IW'(rot_index(32'(log_idx), 32'(base), STATIC, SIZE));
        if (32'(log_idx) >= STATIC) begin
            assert_rot_range_R4: assert (32'(phys_idx) >= STATIC && 32'(phys_idx) < COUNT);
        end
    end

endmodule

// File: rtl/rrm_class.sv
module rrm_class #(
    parameter int unsigned COUNT  = 128,
    parameter int unsigned STATIC = 32,
    parameter int unsigned NPORT  = 3,
    parameter int unsigned IW     = 7,
    parameter int unsigned BW     = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    input  logic [IW-1:0] log_idx  [NPORT],
    output logic [IW-1:0] phys_idx [NPORT]
);

    localparam int unsigned SIZE = COUNT - STATIC;

    logic [BW-1:0] base;

    rrm_base_ctr #(.SIZE(SIZE), .W(BW)) u_base (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .step (step),
        .base (base)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        rrm_lookup #(.COUNT(COUNT), .STATIC(STATIC), .IW(IW), .BW(BW)) u_lk (
            .log_idx  (log_idx[p]),
            .base     (base),
            .phys_idx (phys_idx[p])
        );
    end

endmodule

// File: rtl/rot_reg_remap.sv
module rot_reg_remap
    import rrm_pkg::*;
#(
    parameter int unsigned GR_COUNT  = 128,
    parameter int unsigned GR_STATIC = 32,
    parameter int unsigned FR_COUNT  = 128,
    parameter int unsigned FR_STATIC = 32,
    parameter int unsigned PR_COUNT  = 64,
    parameter int unsigned PR_STATIC = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          rot_step,
    input  logic                          base_clear,
    input  logic [$clog2(GR_COUNT)-1:0]   gr_src0_log,
    input  logic [$clog2(GR_COUNT)-1:0]   gr_src1_log,
    input  logic [$clog2(GR_COUNT)-1:0]   gr_dst_log,
    output logic [$clog2(GR_COUNT)-1:0]   gr_src0_phys,
    output logic [$clog2(GR_COUNT)-1:0]   gr_src1_phys,
    output logic [$clog2(GR_COUNT)-1:0]   gr_dst_phys,
    output logic                          gr_src0_zero,
    output logic                          gr_src1_zero,
    output logic                          gr_dst_zero,
    input  logic [$clog2(FR_COUNT)-1:0]   fr_src0_log,
    input  logic [$clog2(FR_COUNT)-1:0]   fr_src1_log,
    input  logic [$clog2(FR_COUNT)-1:0]   fr_dst_log,
    output logic [$clog2(FR_COUNT)-1:0]   fr_src0_phys,
    output logic [$clog2(FR_COUNT)-1:0]   fr_src1_phys,
    output logic [$clog2(FR_COUNT)-1:0]   fr_dst_phys,
    output logic [1:0]                    fr_src0_const,
    output logic [1:0]                    fr_src1_const,
    output logic [1:0]                    fr_dst_const,
    input  logic [$clog2(PR_COUNT)-1:0]   pr_src0_log,
    input  logic [$clog2(PR_COUNT)-1:0]   pr_src1_log,
    input  logic [$clog2(PR_COUNT)-1:0]   pr_dst_log,
    output logic [$clog2(PR_COUNT)-1:0]   pr_src0_phys,
    output logic [$clog2(PR_COUNT)-1:0]   pr_src1_phys,
    output logic [$clog2(PR_COUNT)-1:0]   pr_dst_phys
);

    localparam int unsigned NPORT = 3;
    localparam int unsigned GIW = $clog2(GR_COUNT);
    localparam int unsigned FIW = $clog2(FR_COUNT);
    localparam int unsigned PIW = $clog2(PR_COUNT);
    localparam int unsigned GBW = $clog2(GR_COUNT - GR_STATIC);
    localparam int unsigned FBW = $clog2(FR_COUNT - FR_STATIC);
    localparam int unsigned PBW = $clog2(PR_COUNT - PR_STATIC);

    logic [GIW-1:0] gr_log [NPORT];
    logic [GIW-1:0] gr_phy [NPORT];
    logic [FIW-1:0] fr_log [NPORT];
    logic [FIW-1:0] fr_phy [NPORT];
    logic [PIW-1:0] pr_log [NPORT];
    logic [PIW-1:0] pr_phy [NPORT];

    assign gr_log[0] = gr_src0_log;
    assign gr_log[1] = gr_src1_log;
    assign gr_log[2] = gr_dst_log;
    assign fr_log[0] = fr_src0_log;
    assign fr_log[1] = fr_src1_log;
    assign fr_log[2] = fr_dst_log;
    assign pr_log[0] = pr_src0_log;
    assign pr_log[1] = pr_src1_log;
    assign pr_log[2] = pr_dst_log;

    rrm_class #(.COUNT(GR_COUNT), .STATIC(GR_STATIC), .NPORT(NPORT), .IW(GIW), .BW(GBW)) u_gr (
        .clk (clk), .rst (rst), .clr (base_clear), .step (rot_step),
        .log_idx (gr_log), .phys_idx (gr_phy)
    );

    rrm_class #(.COUNT(FR_COUNT), .STATIC(FR_STATIC), .NPORT(NPORT), .IW(FIW), .BW(FBW)) u_fr (
        .clk (clk), .rst (rst), .clr (base_clear), .step (rot_step),
        .log_idx (fr_log), .phys_idx (fr_phy)
    );

    rrm_class #(.COUNT(PR_COUNT), .STATIC(PR_STATIC), .NPORT(NPORT), .IW(PIW), .BW(PBW)) u_pr (
        .clk (clk), .rst (rst), .clr (base_clear), .step (rot_step),
        .log_idx (pr_log), .phys_idx (pr_phy)
    );

    assign gr_src0_phys = gr_phy[0];
    assign gr_src1_phys = gr_phy[1];
    assign gr_dst_phys  = gr_phy[2];
    assign fr_src0_phys = fr_phy[0];
    assign fr_src1_phys = fr_phy[1];
    assign fr_dst_phys  = fr_phy[2];
    assign pr_src0_phys = pr_phy[0];
    assign pr_src1_phys = pr_phy[1];
    assign pr_dst_phys  = pr_phy[2];

    always_comb begin
        gr_src0_zero  = (gr_src0_log == '0);
        gr_src1_zero  = (gr_src1_log == '0);
        gr_dst_zero   = (gr_dst_log == '0);
        fr_src0_const = fr_const_kind(32'(fr_src0_log));
        fr_src1_const = fr_const_kind(32'(fr_src1_log));
        fr_dst_const  = fr_const_kind(32'(fr_dst_log));
    end

    assert_gr0_phys_zero_R10: assert property (@(posedge clk) disable iff (rst)
        gr_src0_zero |-> (gr_src0_phys == '0));

    assert_fr_const_static_R11: assert property (@(posedge clk) disable iff (rst)
        (fr_src0_const != 2'd0) |-> (32'(fr_src0_phys) < 2));

endmodule

// File: tb/rot_reg_remap_bench.sv
module rot_reg_remap_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rot_step = 1'b0;
    logic base_clear = 1'b0;
    logic [6:0] gr_src0_log = '0, gr_src1_log = '0, gr_dst_log = '0;
    logic [6:0] gr_src0_phys, gr_src1_phys, gr_dst_phys;
    logic gr_src0_zero, gr_src1_zero, gr_dst_zero;
    logic [6:0] fr_src0_log = '0, fr_src1_log = '0, fr_dst_log = '0;
    logic [6:0] fr_src0_phys, fr_src1_phys, fr_dst_phys;
    logic [1:0] fr_src0_const, fr_src1_const, fr_dst_const;
    logic [5:0] pr_src0_log = '0, pr_src1_log = '0, pr_dst_log = '0;
    logic [5:0] pr_src0_phys, pr_src1_phys, pr_dst_phys;

    int checks = 0;
    int failures = 0;
    int gb = 0;   // expected general/floating base
    int pb = 0;   // expected predicate base

    always #10 clk = ~clk;

    rot_reg_remap u_rot_reg_remap (
        .clk(clk), .rst(rst), .rot_step(rot_step), .base_clear(base_clear),
        .gr_src0_log(gr_src0_log), .gr_src1_log(gr_src1_log), .gr_dst_log(gr_dst_log),
        .gr_src0_phys(gr_src0_phys), .gr_src1_phys(gr_src1_phys), .gr_dst_phys(gr_dst_phys),
        .gr_src0_zero(gr_src0_zero), .gr_src1_zero(gr_src1_zero), .gr_dst_zero(gr_dst_zero),
        .fr_src0_log(fr_src0_log), .fr_src1_log(fr_src1_log), .fr_dst_log(fr_dst_log),
        .fr_src0_phys(fr_src0_phys), .fr_src1_phys(fr_src1_phys), .fr_dst_phys(fr_dst_phys),
        .fr_src0_const(fr_src0_const), .fr_src1_const(fr_src1_const), .fr_dst_const(fr_dst_const),
        .pr_src0_log(pr_src0_log), .pr_src1_log(pr_src1_log), .pr_dst_log(pr_dst_log),
        .pr_src0_phys(pr_src0_phys), .pr_src1_phys(pr_src1_phys), .pr_dst_phys(pr_dst_phys)
    );

    function automatic int exp_map(int lg, int st, int sz, int b);
        if (lg < st) return lg;
        return st + ((lg - st + b) % sz);
    endfunction

    function automatic int exp_code(int lg);
        return (lg == 0) ? 1 : (lg == 1) ? 2 : 0;
    endfunction

    task automatic cmp(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_all(string req, int g0, int g1, int g2, int f0, int f1, int f2,
                           int p0, int p1, int p2);
        gr_src0_log = 7'(g0); gr_src1_log = 7'(g1); gr_dst_log = 7'(g2);
        fr_src0_log = 7'(f0); fr_src1_log = 7'(f1); fr_dst_log = 7'(f2);
        pr_src0_log = 6'(p0); pr_src1_log = 6'(p1); pr_dst_log = 6'(p2);
        #1;
        cmp(req, "gr_src0_phys", int'(gr_src0_phys), exp_map(g0, 32, 96, gb));
        cmp(req, "gr_src1_phys", int'(gr_src1_phys), exp_map(g1, 32, 96, gb));
        cmp(req, "gr_dst_phys",  int'(gr_dst_phys),  exp_map(g2, 32, 96, gb));
        cmp(req, "fr_src0_phys", int'(fr_src0_phys), exp_map(f0, 32, 96, gb));
        cmp(req, "fr_src1_phys", int'(fr_src1_phys), exp_map(f1, 32, 96, gb));
        cmp(req, "fr_dst_phys",  int'(fr_dst_phys),  exp_map(f2, 32, 96, gb));
        cmp(req, "pr_src0_phys", int'(pr_src0_phys), exp_map(p0, 16, 48, pb));
        cmp(req, "pr_src1_phys", int'(pr_src1_phys), exp_map(p1, 16, 48, pb));
        cmp(req, "pr_dst_phys",  int'(pr_dst_phys),  exp_map(p2, 16, 48, pb));
        cmp(req, "gr_src0_zero", int'(gr_src0_zero), int'(g0 == 0));
        cmp(req, "gr_src1_zero", int'(gr_src1_zero), int'(g1 == 0));
        cmp(req, "gr_dst_zero",  int'(gr_dst_zero),  int'(g2 == 0));
        cmp(req, "fr_src0_const", int'(fr_src0_const), exp_code(f0));
        cmp(req, "fr_src1_const", int'(fr_src1_const), exp_code(f1));
        cmp(req, "fr_dst_const",  int'(fr_dst_const),  exp_code(f2));
    endtask

    task automatic rotate(int n);
        @(negedge clk) rot_step = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            gb = (gb == 0) ? 95 : gb - 1;
            pb = (pb == 0) ? 47 : pb - 1;
        end
        rot_step = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk) base_clear = 1'b1;
        @(negedge clk) base_clear = 1'b0;
        gb = 0; pb = 0;
    endtask

    task automatic t_reset();    // R1
        chk_all("R1", 0, 40, 127, 0, 77, 127, 0, 20, 63);
        chk_all("R1", 31, 32, 100, 1, 32, 64, 15, 16, 47);
    endtask

    task automatic t_static();   // R2 R3
        rotate(5);
        chk_all("R2", 1, 17, 31, 2, 16, 31, 0, 7, 15);
        chk_all("R3", 5, 30, 3, 3, 29, 12, 1, 14, 15);
    endtask

    task automatic t_formula();  // R4 R5
        rotate(7);
        chk_all("R4", 32, 80, 127, 33, 90, 126, 16, 40, 63);
        rotate(60);
        chk_all("R4", 50, 100, 120, 45, 110, 127, 20, 55, 62);
        chk_all("R5", 32, 33, 34, 32, 33, 34, 16, 31, 47);
    endtask

    task automatic t_follow();   // R6
        int g, p;
        chk_all("R6", 40, 0, 0, 40, 0, 0, 30, 0, 0);
        g = int'(gr_src0_phys);
        p = int'(pr_src0_phys);
        rotate(1);
        chk_all("R6", 41, 0, 0, 41, 0, 0, 31, 0, 0);
        cmp("R6", "gr follows value", int'(gr_src0_phys), g);
        cmp("R6", "pr follows value", int'(pr_src0_phys), p);
    endtask

    task automatic t_wrap();     // R7
        int g, p;
        chk_all("R7", 127, 0, 0, 127, 0, 0, 63, 0, 0);
        g = int'(gr_src0_phys);
        p = int'(pr_src0_phys);
        rotate(1);
        chk_all("R7", 32, 0, 0, 32, 0, 0, 16, 0, 0);
        cmp("R7", "gr bottom gets top", int'(gr_src0_phys), g);
        cmp("R7", "pr bottom gets top", int'(pr_src0_phys), p);
    endtask

    task automatic t_full_cycle(); // R8
        do_clear();
        rotate(48);
        chk_all("R8", 32, 0, 0, 32, 0, 0, 16, 63, 40);
        cmp("R8", "pr identity after 48", int'(pr_src0_phys), 16);
        cmp("R8", "gr halfway after 48", int'(gr_src0_phys), 80);
        rotate(48);
        chk_all("R8", 32, 127, 70, 32, 127, 70, 16, 63, 40);
        cmp("R8", "gr identity after 96", int'(gr_src1_phys), 127);
    endtask

    task automatic t_clear();    // R9
        rotate(9);
        @(negedge clk) begin rot_step = 1'b1; base_clear = 1'b1; end
        @(negedge clk) begin rot_step = 1'b0; base_clear = 1'b0; end
        gb = 0; pb = 0;
        chk_all("R9", 32, 127, 64, 32, 127, 64, 16, 63, 40);
        repeat (3) @(negedge clk);
        chk_all("R9", 33, 126, 64, 33, 126, 64, 17, 62, 40);
    endtask

    task automatic t_const();    // R10 R11
        chk_all("R10", 0, 1, 0, 0, 1, 2, 0, 0, 0);
        rotate(3);
        chk_all("R11", 1, 0, 0, 1, 0, 3, 0, 0, 0);
    endtask

    task automatic t_comb();     // R12
        @(negedge clk);
        chk_all("R12", 33, 96, 127, 0, 60, 1, 16, 50, 2);
        chk_all("R12", 96, 127, 33, 60, 1, 0, 50, 2, 16);
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_static();
        t_formula();
        t_follow();
        t_wrap();
        t_full_cycle();
        t_clear();
        t_const();
        t_comb();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule